// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block performs the architectural state update that happens when a hart takes a trap. When a trap request arrives, it decides whether the supervisor level or the machine level will handle the trap. It then stacks the interrupt-enable and privilege fields in the status word and loads the handler's cause, exception-PC and trap-value registers. It also computes the handler entry address, switches the privilege, and drops any outstanding load reservation. All of this is done in one clock edge.

The surrounding core supplies the live program counter, privilege, status word, both delegation masks and both trap-vector registers. It raises `trap_valid_i` for one cycle per trap, together with an interrupt flag, a cause code and a faulting address. Every output is a register and keeps its value until the next trap. The one exception is the reservation flag, which the core can also set.

Top module: `trap_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, `priv_o` is 3 (machine), `pc_o` equals parameter `RESET_PC`, and `status_o`, all six trap registers and `resv_valid_o` are zero.
- R2: Interrupts consult `ideleg_i` and exceptions consult `edeleg_i`, using the bit indexed by the (remapped) cause code. The trap is handled at supervisor level only when `priv_i` is 0 or 1 and that bit is 1. Otherwise it is handled at machine level.
- R3: Status layout: bit 0 supervisor enable, bit 1 machine enable, bit 2 supervisor previous enable, bit 3 machine previous enable, bit 4 supervisor previous privilege, bits 6:5 machine previous privilege. At the handling level, previous-enable takes the current enable, previous-privilege takes `priv_i`, and enable becomes 0. Every other bit is copied from `status_i`.
- R4: The handling level's cause register holds the code in its low `CAUSE_W` bits and the interrupt flag in bit `XLEN-1`. All other bits are zero.
- R5: The handling level's exception-PC register takes `pc_i`.
- R6: `pc_o` is the handling level's vector register with bits 1:0 cleared. When the trap is an interrupt and the vector's bits 1:0 equal 1, 4 times the cause code is added.
- R7: The handling level's trap-value register takes `trap_addr_i` only for exceptions with codes 0, 1, 4, 5, 6, 7, 12, 13 or 15. In every other case it takes zero.
- R8: An exception with code 8 is recorded as code 8 plus `priv_i`: 8 from user, 9 from supervisor, 11 from machine. This remapped code is used for delegation and for the vector offset.
- R9: A trap clears `resv_valid_o` on the next cycle. `resv_set_i` sets it only in a cycle with no trap.
- R10: After a trap, `priv_o` is 1 when the trap was delegated and 3 otherwise. The value 2 never appears.
- R11: The outputs change only on the edge that accepts a trap; the one exception is `resv_valid_o` (R9). The level that does not handle a trap keeps its cause, exception-PC and trap-value registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid_i | input | 1 | One trap accepted this cycle |
| trap_intr_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Raw cause code |
| trap_addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| status_i | input | 7 | Current status word |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| edeleg_i | input | XLEN | Exception delegation mask |
| stvec_i | input | XLEN | Supervisor trap-vector register |
| mtvec_i | input | XLEN | Machine trap-vector register |
| resv_set_i | input | 1 | Load reservation placed |
| priv_o | output | 2 | New privilege |
| pc_o | output | XLEN | New program counter |
| status_o | output | 7 | New status word |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| resv_valid_o | output | 1 | Load reservation valid |

## Verification
The sweep covers every privilege value and both trap kinds, with causes 0 to 15, under three delegation masks: all clear, all set, and a mixed pattern. All-clear against all-set separates the privilege gate from the mask lookup. The mixed pattern shows whether the interrupt mask or the exception mask was indexed, and whether the lookup used the raw or the remapped environment-call code. The low bits of the vector registers step through all four mode values, so the interrupt offset must appear only for mode 1 and only for interrupts. Cause 8 from each privilege exercises the remap, and the fault codes next to non-fault codes exercise the trap-value filter. An idle cycle with a reservation set runs before each trap, which shows that the outputs hold between traps and that a trap then clears the reservation.

// File: rtl/trap_pkg.sv
// trap_pkg: shared constants for the trap entry sequencer.
// Assumes a 7-bit status word with the field layout given below.
package trap_pkg;
    localparam int ST_W        = 7;
    localparam int ST_SIE      = 0;
    localparam int ST_MIE      = 1;
    localparam int ST_SPIE     = 2;
    localparam int ST_MPIE     = 3;
    localparam int ST_SPP      = 4;
    localparam int ST_MPP_LO   = 5;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int ECALL_BASE  = 8;

    // True for exception codes that carry an address in the trap value.
    function automatic logic carries_addr(input int unsigned code);
        case (code)
            0, 1, 4, 5, 6, 7, 12, 13, 15: carries_addr = 1'b1;
            default:                      carries_addr = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/trap_route.sv
// trap_route: combinational routing of one trap request.
// Remaps the environment-call code, picks the delegation mask, decides the
// handling level and filters the trap value. Assumes CAUSE_W >= 4.
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               intr_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    addr_i,
    input  logic [1:0]         priv_i,
    input  logic [XLEN-1:0]    ideleg_i,
    input  logic [XLEN-1:0]    edeleg_i,
    output logic [CAUSE_W-1:0] code_o,
    output logic               to_s_o,
    output logic [XLEN-1:0]    tval_o
);
    localparam logic [CAUSE_W-1:0] ECALL_CODE = CAUSE_W'(ECALL_BASE);

    logic [XLEN-1:0] mask_sel;
    logic [XLEN-1:0] mask_shift;

    // Cause code rewrite: environment calls take the trapping privilege.
    always_comb begin
        if (!intr_i && cause_i == ECALL_CODE)
            code_o = ECALL_CODE + CAUSE_W'(priv_i);
        else
            code_o = cause_i;
    end

    // Delegation decision from the mask matching the trap kind.
    always_comb begin
        mask_sel   = intr_i ? ideleg_i : edeleg_i;
        mask_shift = mask_sel >> code_o;
        to_s_o     = (priv_i <= PRIV_S) && mask_shift[0];
    end

    // Trap value keeps the address only for address-related exceptions.
    always_comb begin
        if (!intr_i && carries_addr(int'(unsigned'(code_o))))
            tval_o = addr_i;
        else
            tval_o = '0;
    end
endmodule

// File: rtl/trap_vector.sv
// trap_vector: handler entry address from a trap-vector register.
// VECTORED=1 adds 4*code for interrupts in mode 1; VECTORED=0 always uses
// the aligned base. Assumes XLEN > CAUSE_W + 2.
module trap_vector #(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 5,
    parameter bit VECTORED = 1'b1
) (
    input  logic [XLEN-1:0]    tvec_i,
    input  logic               intr_i,
    input  logic [CAUSE_W-1:0] code_i,
    output logic [XLEN-1:0]    target_o
);
    localparam int PAD_W = XLEN - CAUSE_W - 2;

    logic [XLEN-1:0] base;

    // Align the base to a word boundary.
    always_comb base = {tvec_i[XLEN-1:2], 2'b00};

    generate
        if (VECTORED) begin : g_vec
            logic [XLEN-1:0] offset;
            // Per-cause offset for vectored interrupts.
            always_comb begin
                if (intr_i && tvec_i[1:0] == 2'b01)
                    offset = {{PAD_W{1'b0}}, code_i, 2'b00};
                else
                    offset = '0;
                target_o = base + offset;
            end
        end else begin : g_direct
            // Single entry point for every trap.
            always_comb target_o = base;
        end
    endgenerate
endmodule

// File: rtl/trap_state.sv
// trap_state: architectural registers written on trap entry.
// Assumes exactly one trap per cycle; outputs hold between traps.
module trap_state
    import trap_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          CAUSE_W  = 5,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_i,
    input  logic               intr_i,
    input  logic               to_s_i,
    input  logic [CAUSE_W-1:0] code_i,
    input  logic [XLEN-1:0]    tval_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [1:0]         priv_i,
    input  logic [ST_W-1:0]    status_i,
    input  logic [XLEN-1:0]    target_i,
    input  logic               resv_set_i,
    output logic [1:0]         priv_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [ST_W-1:0]    status_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o,
    output logic               resv_valid_o
);
    localparam int GAP_W = XLEN - 1 - CAUSE_W;

    logic [XLEN-1:0] cause_word;
    logic [ST_W-1:0] status_next;

    // Cause register image: interrupt flag on top, code at the bottom.
    always_comb cause_word = {intr_i, {GAP_W{1'b0}}, code_i};

    // Stack enable and privilege at the handling level.
    always_comb begin
        status_next = status_i;
        if (to_s_i) begin
            status_next[ST_SPIE] = status_i[ST_SIE];
            status_next[ST_SPP]  = priv_i[0];
            status_next[ST_SIE]  = 1'b0;
        end else begin
            status_next[ST_MPIE] = status_i[ST_MIE];
            status_next[ST_MPP_LO+1:ST_MPP_LO] = priv_i;
            status_next[ST_MIE]  = 1'b0;
        end
    end

    // Privilege, PC and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_o   <= PRIV_M;
            pc_o     <= XLEN'(RESET_PC);
            status_o <= '0;
        end else if (trap_i) begin
            priv_o   <= to_s_i ? PRIV_S : PRIV_M;
            pc_o     <= target_i;
            status_o <= status_next;
        end
    end

    // Supervisor trap registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scause_o <= '0;
            sepc_o   <= '0;
            stval_o  <= '0;
        end else if (trap_i && to_s_i) begin
            scause_o <= cause_word;
            sepc_o   <= pc_i;
            stval_o  <= tval_i;
        end
    end

    // Machine trap registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcause_o <= '0;
            mepc_o   <= '0;
            mtval_o  <= '0;
        end else if (trap_i && !to_s_i) begin
            mcause_o <= cause_word;
            mepc_o   <= pc_i;
            mtval_o  <= tval_i;
        end
    end

    // Load reservation: a trap always wins over a new reservation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resv_valid_o <= 1'b0;
        else if (trap_i)
            resv_valid_o <= 1'b0;
        else if (resv_set_i)
            resv_valid_o <= 1'b1;
    end
endmodule

// File: rtl/trap_entry_seq.sv
// trap_entry_seq: top of the trap entry sequencer.
// Routes a trap request, computes the handler address from the selected
// vector register and commits the new state on the next edge.
// Assumes at most one trap request per cycle.
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          CAUSE_W  = 5,
    parameter bit          VECTORED = 1'b1,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid_i,
    input  logic               trap_intr_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic [XLEN-1:0]    trap_addr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [1:0]         priv_i,
    input  logic [6:0]         status_i,
    input  logic [XLEN-1:0]    ideleg_i,
    input  logic [XLEN-1:0]    edeleg_i,
    input  logic [XLEN-1:0]    stvec_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic               resv_set_i,
    output logic [1:0]         priv_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [6:0]         status_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o,
    output logic               resv_valid_o
);
    logic [CAUSE_W-1:0] code;
    logic               to_s;
    logic [XLEN-1:0]    tval;
    logic [XLEN-1:0]    tvec_sel;
    logic [XLEN-1:0]    target;

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
        .intr_i   (trap_intr_i),
        .cause_i  (trap_cause_i),
        .addr_i   (trap_addr_i),
        .priv_i   (priv_i),
        .ideleg_i (ideleg_i),
        .edeleg_i (edeleg_i),
        .code_o   (code),
        .to_s_o   (to_s),
        .tval_o   (tval)
    );

    // Vector register of the handling level.
    always_comb tvec_sel = to_s ? stvec_i : mtvec_i;

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTORED(VECTORED)) u_vec (
        .tvec_i   (tvec_sel),
        .intr_i   (trap_intr_i),
        .code_i   (code),
        .target_o (target)
    );

    trap_state #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .RESET_PC(RESET_PC)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_i       (trap_valid_i),
        .intr_i       (trap_intr_i),
        .to_s_i       (to_s),
        .code_i       (code),
        .tval_i       (tval),
        .pc_i         (pc_i),
        .priv_i       (priv_i),
        .status_i     (status_i),
        .target_i     (target),
        .resv_set_i   (resv_set_i),
        .priv_o       (priv_o),
        .pc_o         (pc_o),
        .status_o     (status_o),
        .scause_o     (scause_o),
        .sepc_o       (sepc_o),
        .stval_o      (stval_o),
        .mcause_o     (mcause_o),
        .mepc_o       (mepc_o),
        .mtval_o      (mtval_o),
        .resv_valid_o (resv_valid_o)
    );

    // R10: the reserved privilege encoding never reaches the output.
    p_no_priv2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        priv_o != 2'd2);

    // R2: delegation only below machine level.
    p_deleg_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && priv_i == PRIV_M) |-> !to_s);

    // R10: a delegated trap lands in supervisor mode.
    p_deleg_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && to_s) |=> priv_o == PRIV_S);

    // R5: machine exception PC captures the trapping PC.
    p_mepc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !to_s) |=> mepc_o == $past(pc_i));

    // R3: the handling level's enable is cleared.
    p_sie_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && to_s) |=> !status_o[ST_SIE]);

    // R9: a trap drops the reservation.
    p_resv_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> !resv_valid_o);

    // R11: no trap, no change in privilege or PC.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> ($stable(priv_o) && $stable(pc_o)));
endmodule

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
    localparam int XLEN = 32;
    localparam int CW   = 5;
    localparam logic [31:0] RPC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid_i = 1'b0, trap_intr_i = 1'b0, resv_set_i = 1'b0;
    logic [CW-1:0] trap_cause_i = '0;
    logic [XLEN-1:0] trap_addr_i = '0, pc_i = '0, ideleg_i = '0, edeleg_i = '0;
    logic [XLEN-1:0] stvec_i = '0, mtvec_i = '0;
    logic [1:0] priv_i = '0;
    logic [6:0] status_i = '0;
    logic [1:0] priv_o;
    logic [6:0] status_o;
    logic [XLEN-1:0] pc_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
    logic resv_valid_o;

    int n_chk = 0;
    int n_bad = 0;

    // expected model state
    logic [1:0] e_priv;
    logic [6:0] e_st;
    logic [XLEN-1:0] e_pc, e_sc, e_sepc, e_stv, e_mc, e_mepc, e_mtv;

    always #2.5 clk = ~clk;

    trap_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i),
        .trap_intr_i(trap_intr_i), .trap_cause_i(trap_cause_i),
        .trap_addr_i(trap_addr_i), .pc_i(pc_i), .priv_i(priv_i),
        .status_i(status_i), .ideleg_i(ideleg_i), .edeleg_i(edeleg_i),
        .stvec_i(stvec_i), .mtvec_i(mtvec_i), .resv_set_i(resv_set_i),
        .priv_o(priv_o), .pc_o(pc_o), .status_o(status_o),
        .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
        .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o),
        .resv_valid_o(resv_valid_o)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " priv"},   XLEN'(priv_o), XLEN'(e_priv));
        chk({req, " pc"},     pc_o, e_pc);
        chk({req, " status"}, XLEN'(status_o), XLEN'(e_st));
        chk({req, " scause"}, scause_o, e_sc);
        chk({req, " sepc"},   sepc_o, e_sepc);
        chk({req, " stval"},  stval_o, e_stv);
        chk({req, " mcause"}, mcause_o, e_mc);
        chk({req, " mepc"},   mepc_o, e_mepc);
        chk({req, " mtval"},  mtval_o, e_mtv);
    endtask

    function automatic logic is_fault(input int c);
        return (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
                c == 12 || c == 13 || c == 15);
    endfunction

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        e_priv = 2'd3; e_pc = RPC; e_st = '0;
        e_sc = '0; e_sepc = '0; e_stv = '0; e_mc = '0; e_mepc = '0; e_mtv = '0;
        chk_all("R1");
        chk("R1 resv", XLEN'(resv_valid_o), 0);
        rst_n = 1'b1;

        for (int dp = 0; dp < 3; dp++) begin
            for (int pv = 0; pv < 4; pv++) begin
                for (int it = 0; it < 2; it++) begin
                    for (int c = 0; c < 16; c++) begin
                        int code;
                        logic dbit, to_s;
                        logic [XLEN-1:0] dmask, tv, base, cw;
                        n++;
                        // idle cycle with reservation set (R9, R11)
                        @(negedge clk);
                        trap_valid_i = 1'b0;
                        resv_set_i = 1'b1;
                        trap_cause_i = CW'(c ^ 5);
                        pc_i = 32'hDEAD_0000 + XLEN'(n);
                        @(negedge clk);
                        resv_set_i = 1'b0;
                        chk("R9 resv set", XLEN'(resv_valid_o), 1);
                        chk_all("R11 hold");

                        // apply trap
                        ideleg_i = (dp == 0) ? '0 : (dp == 1) ? '1 : 32'hA5A5_5A5A;
                        edeleg_i = (dp == 0) ? '0 : (dp == 1) ? '1 : 32'h5A5A_A5A5;
                        priv_i = 2'(pv);
                        trap_intr_i = it[0];
                        trap_cause_i = CW'(c);
                        trap_addr_i = 32'h1234_0000 ^ XLEN'(n * 7);
                        pc_i = 32'h8000_0000 + XLEN'(n * 4);
                        status_i = 7'(n * 13);
                        stvec_i = 32'h0000_4000 | XLEN'(n % 4);
                        mtvec_i = 32'h0000_8000 | XLEN'((n / 4) % 4);
                        resv_set_i = it[0];
                        trap_valid_i = 1'b1;

                        // model (R2, R3, R4, R5, R6, R7, R8, R10)
                        code = (it == 0 && c == 8) ? 8 + pv : c;
                        dmask = it[0] ? ideleg_i : edeleg_i;
                        dbit = dmask[code];
                        to_s = (pv <= 1) && dbit;
                        tv = (it == 0 && is_fault(code)) ? trap_addr_i : '0;
                        cw = (XLEN'(it) << (XLEN - 1)) | XLEN'(code);
                        e_st = status_i;
                        if (to_s) begin
                            e_st[2] = status_i[0];
                            e_st[4] = priv_i[0];
                            e_st[0] = 1'b0;
                            e_sc = cw; e_sepc = pc_i; e_stv = tv;
                            e_priv = 2'd1;
                            base = stvec_i;
                        end else begin
                            e_st[3] = status_i[1];
                            e_st[6:5] = priv_i;
                            e_st[1] = 1'b0;
                            e_mc = cw; e_mepc = pc_i; e_mtv = tv;
                            e_priv = 2'd3;
                            base = mtvec_i;
                        end
                        e_pc = {base[XLEN-1:2], 2'b00} +
                               ((it == 1 && base[1:0] == 2'b01) ? XLEN'(code * 4) : '0);

                        @(negedge clk);
                        trap_valid_i = 1'b0;
                        resv_set_i = 1'b0;
                        chk_all("R2 R3 R4 R5 R6 R7 R8 R10 trap");
                        chk("R9 resv clear", XLEN'(resv_valid_o), 0);
                    end
                end
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule